// File: doc/BRIEF.md
# Tagged Load/Store Slot Unit

This block is one memory slot of a statically scheduled VLIW core. In a single cycle it handles five operations. It can load a constant into a register. It can move a word between a register and a fixed memory address, in either direction. It can also move a word between a register and a computed address, where the address is the sum of a base register and an index register. Every register and every memory word has a 2-bit type tag beside its 16-bit value. The unit checks these tags before it forms an address or commits a result. A store writes the value and its tag together, and a load brings both back.

The unit reads an external 256-entry tagged register file through three combinational read ports: base, index and store source. It writes back through one write port in the same cycle in which the operation issues. Memory is a single-cycle array with a 16-bit word address, a combinational read path and a write strobe. When a tag check fails, every write is blocked. On the following clock edge the unit raises a fault flag for one cycle, together with the opcode that failed.

Top module: `tagged_lsu_slot`

## Requirements
- R1: Opcode 1 (load constant) writes to register `opDst` in the same cycle. The written tag is `opImmTag`, with integer=00, float=01 and address=10. For an integer tag the value is `opImm[7:0]` sign-extended to 16 bits. For a float or address tag the value is the whole 16-bit `opImm`.
- R2: A load constant whose `opImmTag` is 11 (invalid) writes nothing and counts as a tag fault.
- R3: Opcode 2 (direct load) drives `memAddr` with `opImm`. In the same cycle it writes the memory word's value and tag into register `opDst`.
- R4: Opcode 3 (direct store) writes the value and tag of register `opSrc` to memory at `opImm`. A store never writes the register file.
- R5: Opcode 4 (indexed load) and opcode 5 (indexed store) use a memory address equal to the base value plus the index value, taken modulo 2^16. The base is register `opBase` and the index is register `opIndex`. Opcode 5 stores register `opSrc`, and opcode 4 loads into `opDst`.
- R6: For opcodes 4 and 5, the base register must carry tag 10 (address) and the index register must carry tag 00 (integer). Any other tag pair blocks all writes and counts as a tag fault.
- R7: A store whose source register has tag 11 is a tag fault. So is a load that reads a memory word tagged 11. In both cases no write happens.
- R8: After an operation with a tag fault, `tagFault` is 1 for the next cycle and `faultOp` holds that operation's opcode. After an operation without a fault, `tagFault` is 0 in the next cycle.
- R9: When `opValid` is 0, or the opcode is 0, 6 or 7, the unit writes nothing and raises no fault.
- R10: While reset is held, `tagFault` and `faultOp` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| opValid | input | 1 | An operation is issued this cycle |
| opCode | input | 3 | Operation code |
| opImm | input | 16 | Constant or fixed address |
| opImmTag | input | 2 | Type tag of the constant |
| opBase | input | 8 | Base register specifier |
| opIndex | input | 8 | Index register specifier |
| opSrc | input | 8 | Store source register specifier |
| opDst | input | 8 | Load destination register specifier |
| rfRdAddr0 | output | 8 | Base read port address |
| rfRdData0 | input | 16 | Base read value |
| rfRdTag0 | input | 2 | Base read tag |
| rfRdAddr1 | output | 8 | Index read port address |
| rfRdData1 | input | 16 | Index read value |
| rfRdTag1 | input | 2 | Index read tag |
| rfRdAddr2 | output | 8 | Source read port address |
| rfRdData2 | input | 16 | Source read value |
| rfRdTag2 | input | 2 | Source read tag |
| rfWrEn | output | 1 | Register write strobe |
| rfWrAddr | output | 8 | Register write address |
| rfWrData | output | 16 | Register write value |
| rfWrTag | output | 2 | Register write tag |
| memAddr | output | 16 | Memory word address |
| memRdData | input | 16 | Memory read value |
| memRdTag | input | 2 | Memory read tag |
| memWrEn | output | 1 | Memory write strobe |
| memWrData | output | 16 | Memory write value |
| memWrTag | output | 2 | Memory write tag |
| tagFault | output | 1 | A tag fault occurred in the previous cycle |
| faultOp | output | 3 | Opcode of the faulting operation |

## Verification
Load constants run with integer values that have the top bit set and clear, and with upper immediate bits set that must be dropped. This separates sign extension from zero extension, and both from passing the full 16 bits through. Stores and loads are chained through the same addresses, so a value and its tag must survive the round trip. Indexed accesses are tried with legal tags, with a float base, with a float index, with a sum that wraps past 0xFFFF and with a negative index. These cases check the adder width and that each tag check sits in the right place. Back-to-back faults followed by a clean operation show that the fault flag follows each operation on its own instead of staying latched. Idle cycles and unused opcodes, driven with busy operand fields, show that nothing leaks out.

// File: rtl/lsu_slot_pkg.sv
package lsu_slot_pkg;
  localparam int DATA_W    = 16;
  localparam int ADDR_W    = 16;
  localparam int REG_IDX_W = 8;
  localparam int TAG_W     = 2;
  localparam int OP_W      = 3;
  localparam int INT_IMM_W = 8;

  typedef enum logic [TAG_W-1:0] {
    TAG_INT = 2'b00,
    TAG_FLT = 2'b01,
    TAG_ADR = 2'b10,
    TAG_BAD = 2'b11
  } tag_e;

  typedef enum logic [OP_W-1:0] {
    OP_NOP = 3'd0,
    OP_LDC = 3'd1,
    OP_LDD = 3'd2,
    OP_STD = 3'd3,
    OP_LDX = 3'd4,
    OP_STX = 3'd5
  } op_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic indexed;
    logic selConst;
    logic rfWrite;
    logic memWrite;
    logic fault;
  } slotStrobe_t;
endpackage

// File: rtl/lsu_slot_ctrl.sv
module lsu_slot_ctrl
  import lsu_slot_pkg::*;
#(
  parameter int TW = TAG_W,
  parameter int OW = OP_W
) (
  input  logic          opValid,
  input  logic [OW-1:0] opCode,
  input  logic [TW-1:0] immTag,
  input  logic [TW-1:0] baseTag,
  input  logic [TW-1:0] idxTag,
  input  logic [TW-1:0] srcTag,
  input  logic [TW-1:0] memTag,
  output slotStrobe_t   strobe
);
  logic isLoad, isStore, isIdx, legal, bad, idxOk;

  always_comb begin
    idxOk   = (baseTag == TAG_ADR) && (idxTag == TAG_INT);
    isLoad  = 1'b0;
    isStore = 1'b0;
    isIdx   = 1'b0;
    legal   = 1'b1;
    bad     = 1'b0;
    case (opCode)
      OP_LDC: begin isLoad = 1'b1; bad = (immTag == TAG_BAD); end
      OP_LDD: begin isLoad = 1'b1; bad = (memTag == TAG_BAD); end
      OP_STD: begin isStore = 1'b1; bad = (srcTag == TAG_BAD); end
      OP_LDX: begin
        isLoad = 1'b1; isIdx = 1'b1;
        bad = !idxOk || (memTag == TAG_BAD);
      end
      OP_STX: begin
        isStore = 1'b1; isIdx = 1'b1;
        bad = !idxOk || (srcTag == TAG_BAD);
      end
      default: legal = 1'b0;
    endcase
    legal = legal && opValid;

    strobe          = '0;
    strobe.indexed  = isIdx;
    strobe.selConst = (opCode == OP_LDC);
    strobe.rfWrite  = legal && isLoad && !bad;
    strobe.memWrite = legal && isStore && !bad;
    strobe.fault    = legal && bad;
  end
endmodule

// File: rtl/lsu_slot_dpath.sv
module lsu_slot_dpath
  import lsu_slot_pkg::*;
#(
  parameter int DW  = DATA_W,
  parameter int AW  = ADDR_W,
  parameter int RW  = REG_IDX_W,
  parameter int TW  = TAG_W,
  parameter int OW  = OP_W,
  parameter int IIW = INT_IMM_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  slotStrobe_t   strobe,
  input  logic [OW-1:0] opCode,
  input  logic [DW-1:0] opImm,
  input  logic [TW-1:0] immTag,
  input  logic [RW-1:0] opDst,
  input  logic [DW-1:0] baseData,
  input  logic [DW-1:0] idxData,
  input  logic [DW-1:0] srcData,
  input  logic [TW-1:0] srcTag,
  input  logic [DW-1:0] memRdData,
  input  logic [TW-1:0] memRdTag,
  output logic [AW-1:0] memAddr,
  output logic          memWrEn,
  output logic [DW-1:0] memWrData,
  output logic [TW-1:0] memWrTag,
  output logic          rfWrEn,
  output logic [RW-1:0] rfWrAddr,
  output logic [DW-1:0] rfWrData,
  output logic [TW-1:0] rfWrTag,
  output logic          tagFault,
  output logic [OW-1:0] faultOp
);
  localparam int EXT_W = DW - IIW;

  logic [DW-1:0] intConst, constVal;
  logic [AW-1:0] sumAddr;

  generate
    if (EXT_W > 0) begin : g_sext
      assign intConst = {{EXT_W{opImm[IIW-1]}}, opImm[IIW-1:0]};
    end else begin : g_full
      assign intConst = opImm;
    end
  endgenerate

  assign constVal = (immTag == TAG_INT) ? intConst : opImm;
  assign sumAddr  = baseData[AW-1:0] + idxData[AW-1:0];
  assign memAddr  = strobe.indexed ? sumAddr : opImm[AW-1:0];

  assign memWrEn   = strobe.memWrite;
  assign memWrData = srcData;
  assign memWrTag  = srcTag;

  assign rfWrEn   = strobe.rfWrite;
  assign rfWrAddr = opDst;
  assign rfWrData = strobe.selConst ? constVal : memRdData;
  assign rfWrTag  = strobe.selConst ? immTag : memRdTag;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tagFault <= 1'b0;
      faultOp  <= '0;
    end else begin
      tagFault <= strobe.fault;
      faultOp  <= strobe.fault ? opCode : '0;
    end
  end
endmodule

// File: rtl/tagged_lsu_slot.sv
module tagged_lsu_slot
  import lsu_slot_pkg::*;
#(
  parameter int DW  = DATA_W,
  parameter int AW  = ADDR_W,
  parameter int RW  = REG_IDX_W,
  parameter int TW  = TAG_W,
  parameter int OW  = OP_W,
  parameter int IIW = INT_IMM_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          opValid,
  input  logic [OW-1:0] opCode,
  input  logic [DW-1:0] opImm,
  input  logic [TW-1:0] opImmTag,
  input  logic [RW-1:0] opBase,
  input  logic [RW-1:0] opIndex,
  input  logic [RW-1:0] opSrc,
  input  logic [RW-1:0] opDst,
  output logic [RW-1:0] rfRdAddr0,
  input  logic [DW-1:0] rfRdData0,
  input  logic [TW-1:0] rfRdTag0,
  output logic [RW-1:0] rfRdAddr1,
  input  logic [DW-1:0] rfRdData1,
  input  logic [TW-1:0] rfRdTag1,
  output logic [RW-1:0] rfRdAddr2,
  input  logic [DW-1:0] rfRdData2,
  input  logic [TW-1:0] rfRdTag2,
  output logic          rfWrEn,
  output logic [RW-1:0] rfWrAddr,
  output logic [DW-1:0] rfWrData,
  output logic [TW-1:0] rfWrTag,
  output logic [AW-1:0] memAddr,
  input  logic [DW-1:0] memRdData,
  input  logic [TW-1:0] memRdTag,
  output logic          memWrEn,
  output logic [DW-1:0] memWrData,
  output logic [TW-1:0] memWrTag,
  output logic          tagFault,
  output logic [OW-1:0] faultOp
);
  slotStrobe_t strobe;

  assign rfRdAddr0 = opBase;
  assign rfRdAddr1 = opIndex;
  assign rfRdAddr2 = opSrc;

  lsu_slot_ctrl #(.TW(TW), .OW(OW)) u_ctrl (
    .opValid (opValid),
    .opCode  (opCode),
    .immTag  (opImmTag),
    .baseTag (rfRdTag0),
    .idxTag  (rfRdTag1),
    .srcTag  (rfRdTag2),
    .memTag  (memRdTag),
    .strobe  (strobe)
  );

  lsu_slot_dpath #(.DW(DW), .AW(AW), .RW(RW), .TW(TW), .OW(OW), .IIW(IIW)) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .opCode    (opCode),
    .opImm     (opImm),
    .immTag    (opImmTag),
    .opDst     (opDst),
    .baseData  (rfRdData0),
    .idxData   (rfRdData1),
    .srcData   (rfRdData2),
    .srcTag    (rfRdTag2),
    .memRdData (memRdData),
    .memRdTag  (memRdTag),
    .memAddr   (memAddr),
    .memWrEn   (memWrEn),
    .memWrData (memWrData),
    .memWrTag  (memWrTag),
    .rfWrEn    (rfWrEn),
    .rfWrAddr  (rfWrAddr),
    .rfWrData  (rfWrData),
    .rfWrTag   (rfWrTag),
    .tagFault  (tagFault),
    .faultOp   (faultOp)
  );
endmodule

// File: rtl/tagged_lsu_slot_chk.sv
module tagged_lsu_slot_chk #(
  parameter int DW = 16,
  parameter int AW = 16,
  parameter int TW = 2,
  parameter int OW = 3
) (
  input logic          clk,
  input logic          rstN,
  input logic          opValid,
  input logic [OW-1:0] opCode,
  input logic [DW-1:0] opImm,
  input logic [TW-1:0] rfRdTag0,
  input logic [TW-1:0] rfRdTag1,
  input logic          rfWrEn,
  input logic [TW-1:0] rfWrTag,
  input logic [AW-1:0] memAddr,
  input logic          memWrEn,
  input logic [TW-1:0] memWrTag,
  input logic          tagFault,
  input logic [OW-1:0] faultOp
);
  assert_store_no_rf_R4: assert property (@(posedge clk) disable iff (!rstN)
    !(rfWrEn && memWrEn));

  assert_direct_addr_R3: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opCode == 3'd2) |-> (memAddr == opImm[AW-1:0]));

  assert_idx_load_tags_R6: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opCode == 3'd4 && rfWrEn) |-> (rfRdTag0 == 2'b10 && rfRdTag1 == 2'b00));

  assert_idx_store_tags_R6: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opCode == 3'd5 && memWrEn) |-> (rfRdTag0 == 2'b10 && rfRdTag1 == 2'b00));

  assert_rf_tag_legal_R7: assert property (@(posedge clk) disable iff (!rstN)
    rfWrEn |-> (rfWrTag != 2'b11));

  assert_mem_tag_legal_R7: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn |-> (memWrTag != 2'b11));

  assert_write_then_clean_R8: assert property (@(posedge clk) disable iff (!rstN)
    (rfWrEn || memWrEn) |=> !tagFault);

  assert_fault_opcode_R8: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opCode != 3'd0) |=> (!tagFault || faultOp == $past(opCode)));

  assert_idle_no_write_R9: assert property (@(posedge clk) disable iff (!rstN)
    !opValid |-> (!rfWrEn && !memWrEn));

  assert_idle_no_fault_R9: assert property (@(posedge clk) disable iff (!rstN)
    !opValid |=> !tagFault);
endmodule

bind tagged_lsu_slot tagged_lsu_slot_chk #(.DW(DW), .AW(AW), .TW(TW), .OW(OW)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .opValid  (opValid),
  .opCode   (opCode),
  .opImm    (opImm),
  .rfRdTag0 (rfRdTag0),
  .rfRdTag1 (rfRdTag1),
  .rfWrEn   (rfWrEn),
  .rfWrTag  (rfWrTag),
  .memAddr  (memAddr),
  .memWrEn  (memWrEn),
  .memWrTag (memWrTag),
  .tagFault (tagFault),
  .faultOp  (faultOp)
);

// File: tb/tagged_lsu_slot_bench.sv
module tagged_lsu_slot_bench;
  localparam int CLK_PERIOD = 10;
  localparam int MEM_IDX_W = 12;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic opValid = 1'b0;
  logic [2:0] opCode = '0;
  logic [15:0] opImm = '0;
  logic [1:0] opImmTag = '0;
  logic [7:0] opBase = '0, opIndex = '0, opSrc = '0, opDst = '0;
  logic [7:0] rfRdAddr0, rfRdAddr1, rfRdAddr2, rfWrAddr;
  logic [15:0] rfRdData0, rfRdData1, rfRdData2, rfWrData;
  logic [1:0] rfRdTag0, rfRdTag1, rfRdTag2, rfWrTag;
  logic rfWrEn, memWrEn, tagFault;
  logic [15:0] memAddr, memRdData, memWrData;
  logic [1:0] memRdTag, memWrTag;
  logic [2:0] faultOp;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // Environment: register file and memory models
  logic [15:0] rfD [256];
  logic [1:0]  rfT [256];
  logic [15:0] mD  [1<<MEM_IDX_W];
  logic [1:0]  mT  [1<<MEM_IDX_W];

  assign rfRdData0 = rfD[rfRdAddr0];
  assign rfRdTag0  = rfT[rfRdAddr0];
  assign rfRdData1 = rfD[rfRdAddr1];
  assign rfRdTag1  = rfT[rfRdAddr1];
  assign rfRdData2 = rfD[rfRdAddr2];
  assign rfRdTag2  = rfT[rfRdAddr2];
  assign memRdData = mD[memAddr[MEM_IDX_W-1:0]];
  assign memRdTag  = mT[memAddr[MEM_IDX_W-1:0]];

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 256; i++) begin rfD[i] <= '0; rfT[i] <= 2'b11; end
      for (int i = 0; i < (1<<MEM_IDX_W); i++) begin mD[i] <= '0; mT[i] <= 2'b11; end
    end else begin
      if (rfWrEn) begin rfD[rfWrAddr] <= rfWrData; rfT[rfWrAddr] <= rfWrTag; end
      if (memWrEn) begin
        mD[memAddr[MEM_IDX_W-1:0]] <= memWrData;
        mT[memAddr[MEM_IDX_W-1:0]] <= memWrTag;
      end
    end
  end

  tagged_lsu_slot u_tagged_lsu_slot (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opCode(opCode), .opImm(opImm),
    .opImmTag(opImmTag), .opBase(opBase), .opIndex(opIndex), .opSrc(opSrc), .opDst(opDst),
    .rfRdAddr0(rfRdAddr0), .rfRdData0(rfRdData0), .rfRdTag0(rfRdTag0),
    .rfRdAddr1(rfRdAddr1), .rfRdData1(rfRdData1), .rfRdTag1(rfRdTag1),
    .rfRdAddr2(rfRdAddr2), .rfRdData2(rfRdData2), .rfRdTag2(rfRdTag2),
    .rfWrEn(rfWrEn), .rfWrAddr(rfWrAddr), .rfWrData(rfWrData), .rfWrTag(rfWrTag),
    .memAddr(memAddr), .memRdData(memRdData), .memRdTag(memRdTag),
    .memWrEn(memWrEn), .memWrData(memWrData), .memWrTag(memWrTag),
    .tagFault(tagFault), .faultOp(faultOp)
  );

  typedef struct {
    logic rfWe; logic [7:0] rfA; logic [15:0] rfDat; logic [1:0] rfTg;
    logic memWe; logic [15:0] memA; logic [15:0] memDat; logic [1:0] memTg;
    logic chkA; logic flt; logic [2:0] fop; string req;
  } exp_t;

  exp_t expQ[$];

  // Driver: sets one operation per cycle and queues what must come out
  task automatic issue(input logic v, input logic [2:0] op, input logic [15:0] imm,
                       input logic [1:0] itag, input logic [7:0] rb, input logic [7:0] ri,
                       input logic [7:0] rs, input logic [7:0] rd,
                       input logic rfWe, input logic [15:0] rfDat, input logic [1:0] rfTg,
                       input logic memWe, input logic [15:0] memA, input logic [15:0] memDat,
                       input logic [1:0] memTg, input logic chkA, input logic flt, input string req);
    exp_t e;
    @(posedge clk); #1;
    opValid = v; opCode = op; opImm = imm; opImmTag = itag;
    opBase = rb; opIndex = ri; opSrc = rs; opDst = rd;
    e.rfWe = rfWe; e.rfA = rd; e.rfDat = rfDat; e.rfTg = rfTg;
    e.memWe = memWe; e.memA = memA; e.memDat = memDat; e.memTg = memTg;
    e.chkA = chkA; e.flt = flt; e.fop = flt ? op : 3'd0; e.req = req;
    expQ.push_back(e);
  endtask

  task automatic idle(input string req);
    issue(1'b0, 3'd3, 16'hBEEF, 2'b00, 8'd3, 8'd4, 8'd2, 8'd7,
          0, 0, 0, 0, 0, 0, 0, 0, 0, req);
  endtask

  // Monitor: compares writes in the issue cycle, fault in the next cycle
  logic pendValid = 1'b0, pendFlt = 1'b0;
  logic [2:0] pendOp = '0;
  string pendReq = "";

  always @(negedge clk) begin
    if (rstN) begin
      if (pendValid) begin
        total++;
        if (tagFault !== pendFlt || (pendFlt && faultOp !== pendOp)) begin
          bad++;
          $display("FAIL %s fault: actual flag=%0b op=%0d expected flag=%0b op=%0d",
                   pendReq, tagFault, faultOp, pendFlt, pendOp);
        end
      end
      pendValid = 1'b0;
      if (expQ.size() > 0) begin
        exp_t e;
        e = expQ.pop_front();
        total++;
        if (rfWrEn !== e.rfWe ||
            (e.rfWe && (rfWrAddr !== e.rfA || rfWrData !== e.rfDat || rfWrTag !== e.rfTg))) begin
          bad++;
          $display("FAIL %s rf write: actual en=%0b a=%0d d=%h t=%b expected en=%0b a=%0d d=%h t=%b",
                   e.req, rfWrEn, rfWrAddr, rfWrData, rfWrTag, e.rfWe, e.rfA, e.rfDat, e.rfTg);
        end
        total++;
        if (memWrEn !== e.memWe || ((e.memWe || e.chkA) && memAddr !== e.memA) ||
            (e.memWe && (memWrData !== e.memDat || memWrTag !== e.memTg))) begin
          bad++;
          $display("FAIL %s mem: actual en=%0b a=%h d=%h t=%b expected en=%0b a=%h d=%h t=%b",
                   e.req, memWrEn, memAddr, memWrData, memWrTag, e.memWe, e.memA, e.memDat, e.memTg);
        end
        pendValid = 1'b1; pendFlt = e.flt; pendOp = e.fop; pendReq = e.req;
      end
    end
  end

  logic finished = 1'b0;

  initial begin
    rstN = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    total++;
    if (tagFault !== 1'b0 || faultOp !== 3'd0) begin
      bad++;
      $display("FAIL R10 reset: actual flag=%0b op=%0d expected flag=0 op=0", tagFault, faultOp);
    end
    @(posedge clk); #1 rstN = 1'b1;

    // R1: constants
    issue(1, 3'd1, 16'hAB85, 2'b00, 0, 0, 0, 8'd1, 1, 16'hFF85, 2'b00, 0, 0, 0, 0, 0, 0, "R1 int negative");
    issue(1, 3'd1, 16'h3C00, 2'b01, 0, 0, 0, 8'd2, 1, 16'h3C00, 2'b01, 0, 0, 0, 0, 0, 0, "R1 float");
    issue(1, 3'd1, 16'h0100, 2'b10, 0, 0, 0, 8'd3, 1, 16'h0100, 2'b10, 0, 0, 0, 0, 0, 0, "R1 address");
    issue(1, 3'd1, 16'h7705, 2'b00, 0, 0, 0, 8'd4, 1, 16'h0005, 2'b00, 0, 0, 0, 0, 0, 0, "R1 int positive");
    // R2 then R7 back to back: two faults in a row, then a clean op (R8)
    issue(1, 3'd1, 16'h1234, 2'b11, 0, 0, 0, 8'd5, 0, 0, 0, 0, 0, 0, 0, 0, 1, "R2 invalid const R8");
    issue(1, 3'd3, 16'h0050, 2'b00, 0, 0, 8'd5, 0, 0, 0, 0, 0, 16'h0050, 0, 0, 1, 1, "R7 store invalid src R8");
    // R4 direct store, R3 direct load round trip
    issue(1, 3'd3, 16'h0040, 2'b00, 0, 0, 8'd2, 0, 0, 0, 0, 1, 16'h0040, 16'h3C00, 2'b01, 1, 0, "R4 direct store R8");
    issue(1, 3'd2, 16'h0040, 2'b00, 0, 0, 0, 8'd6, 1, 16'h3C00, 2'b01, 0, 16'h0040, 0, 0, 1, 0, "R3 direct load");
    issue(1, 3'd2, 16'h0200, 2'b00, 0, 0, 0, 8'd6, 0, 0, 0, 0, 16'h0200, 0, 0, 1, 1, "R7 load invalid word");
    // R5 indexed store/load
    issue(1, 3'd5, 16'h0000, 2'b00, 8'd3, 8'd4, 8'd1, 0, 0, 0, 0, 1, 16'h0105, 16'hFF85, 2'b00, 1, 0, "R5 indexed store");
    issue(1, 3'd4, 16'h0000, 2'b00, 8'd3, 8'd4, 0, 8'd7, 1, 16'hFF85, 2'b00, 0, 16'h0105, 0, 0, 1, 0, "R5 indexed load");
    // R6 bad tags
    issue(1, 3'd4, 16'h0000, 2'b00, 8'd2, 8'd4, 0, 8'd7, 0, 0, 0, 0, 0, 0, 0, 0, 1, "R6 float base");
    issue(1, 3'd5, 16'h0000, 2'b00, 8'd3, 8'd2, 8'd1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, "R6 float index");
    // R5 wrap and negative index
    issue(1, 3'd1, 16'hFFF0, 2'b10, 0, 0, 0, 8'd8, 1, 16'hFFF0, 2'b10, 0, 0, 0, 0, 0, 0, "R1 address high");
    issue(1, 3'd1, 16'h0020, 2'b00, 0, 0, 0, 8'd9, 1, 16'h0020, 2'b00, 0, 0, 0, 0, 0, 0, "R1 int small");
    issue(1, 3'd5, 16'h0000, 2'b00, 8'd8, 8'd9, 8'd4, 0, 0, 0, 0, 1, 16'h0010, 16'h0005, 2'b00, 1, 0, "R5 wrap store");
    issue(1, 3'd2, 16'h0010, 2'b00, 0, 0, 0, 8'd10, 1, 16'h0005, 2'b00, 0, 16'h0010, 0, 0, 1, 0, "R3 load wrapped word");
    issue(1, 3'd4, 16'h0000, 2'b00, 8'd3, 8'd1, 0, 8'd11, 0, 0, 0, 0, 16'h0085, 0, 0, 1, 1, "R5 negative index R7");
    // R9 idle and unused opcodes
    idle("R9 idle");
    issue(1, 3'd6, 16'h0040, 2'b00, 8'd3, 8'd4, 8'd2, 8'd12, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R9 opcode 6");
    issue(1, 3'd0, 16'h0040, 2'b11, 8'd3, 8'd4, 8'd5, 8'd12, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R9 opcode 0");
    // R9: register 12 must still be empty; read it back through a store
    issue(1, 3'd3, 16'h0060, 2'b00, 0, 0, 8'd12, 0, 0, 0, 0, 0, 16'h0060, 0, 0, 1, 1, "R9 reg untouched");
    idle("R9 tail");
    idle("R9 tail");
    @(posedge clk); @(posedge clk);
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule